// File: doc/BRIEF.md
# Vector Loop State Register Unit

This unit holds the architectural state of a scalar core's hardware vector loop. The state has five fields: a maximum vector length, the current vector length, a sub-vector group size, and source and destination element step counters. Software reaches the fields through a write port that selects either one field or the whole packed word. Every write is checked for legal values. A write with an illegal value is refused, and the unit raises an illegal-instruction pulse with a cause code.

The unit also follows the trap flow. When the trap unit saves the program counter, it strobes `trap_save_i`, and the live state is copied into a save register as an equal partner of the PC. On trap return, `trap_rest_i` copies the saved word back into the live state. When the core enters or leaves a privilege level, `priv_swap_i` exchanges the live state with that level's own shadow copy.

Packed word layout: bits [6:0] hold the maximum length, bits [13:7] the vector length, bits [15:14] the group size minus one, bits [22:16] the source step and bits [29:23] the destination step. Bits [31:30] read as zero.

Top module: `vstate_unit`

## Requirements
- R1: After reset, `state_o` and `save_o` both read 32'h0000_0001, which is maximum 1, length 0, group 1 and both steps 0. `ill_o` is 0 and `ill_cause_o` is 0. Every shadow copy holds the same word.
- R2: `state_o` presents the live state in the packed layout given above, with bits [31:30] equal to zero. It updates on the clock edge that accepts a change.
- R3: Write select 0 sets the maximum length. Values 1..64 are accepted. If the current length exceeds the new maximum, the length becomes the new maximum. The values 0 and anything above 64 trap with cause 1.
- R4: Write select 1 sets the length. A value above 64 traps with cause 2. Otherwise the length becomes the smaller of the written value and the current maximum.
- R5: Write select 2 sets the group size. Values 1..4 are stored as the value minus one. Any other value traps with cause 3.
- R6: Write selects 3 (source step) and 4 (destination step) accept values 0..63. A value of 64 or more traps with cause 4.
- R7: Write select 5 loads the whole packed word. The fields are checked in this order: maximum (0 or above 64 gives cause 1), then length (above 64 gives cause 2), then the steps (either 64 or more gives cause 4). A length above the new maximum is clamped to it. Bits [31:30] are ignored. Selects 6 and 7 change nothing and do not trap.
- R8: A trapping write leaves all state unchanged. `ill_o` is high for exactly the cycle after each trapping write, with the cause on `ill_cause_o`. `ill_cause_o` is 0 whenever `ill_o` is low.
- R9: `trap_save_i` copies the live state, as it was before that edge, into the save register. A write in the same cycle still applies to the live state.
- R10: `trap_rest_i` loads the live state from the save register. If save and restore coincide, the save register takes the old live state and the live state takes the old saved word.
- R11: `priv_swap_i` with level 0, 1 or 2 exchanges the live state with that level's shadow copy. Level 3 has no effect. A restore in the same cycle wins, and the swap is dropped.
- R12: A write in a cycle with `trap_rest_i` or `priv_swap_i` high has no effect and raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write request |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 32 | Write value |
| trap_save_i | input | 1 | Save the live state alongside the PC |
| trap_rest_i | input | 1 | Restore the live state on trap return |
| priv_swap_i | input | 1 | Privilege entry/exit swap strobe |
| priv_lvl_i | input | 2 | Level whose shadow takes part in the swap |
| state_o | output | 32 | Packed live state |
| save_o | output | 32 | Packed save register |
| ill_o | output | 1 | Illegal-write pulse |
| ill_cause_o | output | 3 | Cause of the illegal write |

## Verification
On every cycle, the assertions check the live-state invariants: the maximum stays within 1..64, the length never exceeds the maximum, the steps stay below 64 and the unused bits stay zero. They also check that the state holds still while a trap pulse is out, that the cause code is present exactly when the pulse is, and the one-cycle effects of save and restore. The priority among restore, swap and write, the exact clamping, the cause ordering in packed writes, and the round trip through each shadow copy can only be shown by the bench. It compares every output after each cycle with a reference model.

// File: rtl/vstate_pkg.sv
package vstate_pkg;
  localparam int XLEN = 64;
  localparam int FW   = $clog2(XLEN + 1);
  localparam int DW   = 32;

  typedef struct packed {
    logic [FW-1:0] dst;
    logic [FW-1:0] src;
    logic [1:0]    sub;
    logic [FW-1:0] vl;
    logic [FW-1:0] mvl;
  } vstate_t;

  localparam int SW = $bits(vstate_t);

  typedef enum logic [2:0] {
    SEL_MVL = 3'd0,
    SEL_VL  = 3'd1,
    SEL_SUB = 3'd2,
    SEL_SRC = 3'd3,
    SEL_DST = 3'd4,
    SEL_ALL = 3'd5
  } wsel_e;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_MVL  = 3'd1,
    CAUSE_VL   = 3'd2,
    CAUSE_SUB  = 3'd3,
    CAUSE_STEP = 3'd4
  } cause_e;

  function automatic vstate_t vstate_rst();
    vstate_t s;
    s     = '0;
    s.mvl = FW'(1);
    return s;
  endfunction
endpackage

// File: rtl/vstate_check.sv
module vstate_check
  import vstate_pkg::*;
(
  input  vstate_t         cur_i,
  input  logic [2:0]      sel_i,
  input  logic [DW-1:0]   data_i,
  output vstate_t         nxt_o,
  output cause_e          cause_o
);
  localparam logic [DW-1:0] LIM_D  = DW'(XLEN);
  localparam logic [FW-1:0] LIM_F  = FW'(XLEN);
  localparam logic [DW-1:0] SUB_MX = DW'(4);

  logic [FW-1:0] a_mvl, a_vl, a_src, a_dst;
  logic [DW-1:0] d_m1;

  assign a_mvl = data_i[FW-1:0];
  assign a_vl  = data_i[2*FW-1:FW];
  assign a_src = data_i[3*FW+1:2*FW+2];
  assign a_dst = data_i[4*FW+1:3*FW+2];
  assign d_m1  = data_i - DW'(1);

  always_comb begin
    nxt_o   = cur_i;
    cause_o = CAUSE_NONE;
    case (sel_i)
      SEL_MVL: begin
        if (data_i == '0 || data_i > LIM_D) cause_o = CAUSE_MVL;
        else begin
          nxt_o.mvl = data_i[FW-1:0];
          if (cur_i.vl > data_i[FW-1:0]) nxt_o.vl = data_i[FW-1:0];
        end
      end
      SEL_VL: begin
        if (data_i > LIM_D) cause_o = CAUSE_VL;
        else nxt_o.vl = (data_i[FW-1:0] > cur_i.mvl) ? cur_i.mvl : data_i[FW-1:0];
      end
      SEL_SUB: begin
        if (data_i == '0 || data_i > SUB_MX) cause_o = CAUSE_SUB;
        else nxt_o.sub = d_m1[1:0];
      end
      SEL_SRC: begin
        if (data_i >= LIM_D) cause_o = CAUSE_STEP;
        else nxt_o.src = data_i[FW-1:0];
      end
      SEL_DST: begin
        if (data_i >= LIM_D) cause_o = CAUSE_STEP;
        else nxt_o.dst = data_i[FW-1:0];
      end
      SEL_ALL: begin
        // ordered checks: max, length, steps
        if (a_mvl == '0 || a_mvl > LIM_F) cause_o = CAUSE_MVL;
        else if (a_vl > LIM_F)            cause_o = CAUSE_VL;
        else if (a_src >= LIM_F || a_dst >= LIM_F) cause_o = CAUSE_STEP;
        else begin
          nxt_o.mvl = a_mvl;
          nxt_o.vl  = (a_vl > a_mvl) ? a_mvl : a_vl;
          nxt_o.sub = data_i[2*FW+1:2*FW];
          nxt_o.src = a_src;
          nxt_o.dst = a_dst;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vstate_shadow.sv
module vstate_shadow
  import vstate_pkg::*;
#(
  parameter int NUM_LVL = 3,
  parameter int LW      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_en_i,
  input  logic [LW-1:0] lvl_i,
  input  vstate_t       live_i,
  output vstate_t       shadow_o,
  output logic          lvl_ok_o
);
  vstate_t bank [NUM_LVL];

  assign lvl_ok_o = int'(lvl_i) < NUM_LVL;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank[g] <= vstate_rst();
      else if (swap_en_i && int'(lvl_i) == g) bank[g] <= live_i;
    end
  end

  always_comb begin
    shadow_o = vstate_rst();
    for (int i = 0; i < NUM_LVL; i++)
      if (int'(lvl_i) == i) shadow_o = bank[i];
  end
endmodule

// File: rtl/vstate_unit.sv
module vstate_unit
  import vstate_pkg::*;
#(
  parameter  int NUM_LVL = 3,
  localparam int LW      = $clog2(NUM_LVL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          trap_save_i,
  input  logic          trap_rest_i,
  input  logic          priv_swap_i,
  input  logic [LW-1:0] priv_lvl_i,
  output logic [DW-1:0] state_o,
  output logic [DW-1:0] save_o,
  output logic          ill_o,
  output logic [2:0]    ill_cause_o
);
  localparam logic [FW-1:0] LIM_F = FW'(XLEN);

  vstate_t live_q, save_q, nxt, shadow;
  cause_e  cause, cause_q;
  logic    lvl_ok, swap_go, wr_go, ill_q;

  assign wr_go   = wr_en_i && !trap_rest_i && !priv_swap_i;
  assign swap_go = priv_swap_i && lvl_ok && !trap_rest_i;

  vstate_check i_check (
    .cur_i   (live_q),
    .sel_i   (wr_sel_i),
    .data_i  (wr_data_i),
    .nxt_o   (nxt),
    .cause_o (cause)
  );

  vstate_shadow #(.NUM_LVL(NUM_LVL), .LW(LW)) i_shadow (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swap_en_i (swap_go),
    .lvl_i     (priv_lvl_i),
    .live_i    (live_q),
    .shadow_o  (shadow),
    .lvl_ok_o  (lvl_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= vstate_rst();
      save_q  <= vstate_rst();
      ill_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      if (trap_save_i) save_q <= live_q;
      if (trap_rest_i)                        live_q <= save_q;
      else if (swap_go)                       live_q <= shadow;
      else if (wr_go && cause == CAUSE_NONE)  live_q <= nxt;
      ill_q   <= wr_go && cause != CAUSE_NONE;
      cause_q <= wr_go ? cause : CAUSE_NONE;
    end
  end

  assign state_o     = {{(DW-SW){1'b0}}, live_q};
  assign save_o      = {{(DW-SW){1'b0}}, save_q};
  assign ill_o       = ill_q;
  assign ill_cause_o = cause_q;

  // R3
  mvl_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q.mvl != '0 && live_q.mvl <= LIM_F);
  // R4
  vl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q.vl <= live_q.mvl);
  // R6
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q.src < LIM_F && live_q.dst < LIM_F);
  // R2
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[DW-1:SW] == '0);
  // R8
  trap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_o |-> $stable(state_o));
  // R8
  cause_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ill_o == (ill_cause_o != 3'd0));
  // R9
  save_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_save_i |=> save_o == $past(state_o));
  // R10
  rest_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_rest_i |=> state_o == $past(save_o));
  // R12
  blocked_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (trap_rest_i || priv_swap_i)) |=> !ill_o);
endmodule

// File: tb/test_vstate_unit.sv
module test_vstate_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, t_save = 1'b0, t_rest = 1'b0, p_swap = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  p_lvl = '0;
  logic [31:0] state, save;
  logic        ill;
  logic [2:0]  ill_cause;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int m_mvl, m_vl, m_sub, m_src, m_dst;
  logic [31:0] m_save;
  logic [31:0] m_sh [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  vstate_unit i_vstate_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .trap_save_i(t_save), .trap_rest_i(t_rest),
    .priv_swap_i(p_swap), .priv_lvl_i(p_lvl), .state_o(state),
    .save_o(save), .ill_o(ill), .ill_cause_o(ill_cause)
  );

  function automatic logic [31:0] pack(int mx, int v, int sb, int s, int d);
    return {2'b00, 7'(d), 7'(s), 2'(sb - 1), 7'(v), 7'(mx)};
  endfunction

  function automatic logic [31:0] live_word();
    return pack(m_mvl, m_vl, m_sub, m_src, m_dst);
  endfunction

  task automatic load_word(input logic [31:0] w);
    m_mvl = int'(w[6:0]); m_vl = int'(w[13:7]); m_sub = int'(w[15:14]) + 1;
    m_src = int'(w[22:16]); m_dst = int'(w[29:23]);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference write: returns cause, updates model when legal
  function automatic int ref_write(input int sel, input logic [31:0] d);
    int a_m, a_v, a_s, a_d;
    case (sel)
      0: begin
        if (d == 0 || d > 64) return 1;
        m_mvl = int'(d); if (m_vl > m_mvl) m_vl = m_mvl;
      end
      1: begin
        if (d > 64) return 2;
        m_vl = (int'(d) > m_mvl) ? m_mvl : int'(d);
      end
      2: begin
        if (d < 1 || d > 4) return 3;
        m_sub = int'(d);
      end
      3: begin if (d >= 64) return 4; m_src = int'(d); end
      4: begin if (d >= 64) return 4; m_dst = int'(d); end
      5: begin
        a_m = int'(d[6:0]); a_v = int'(d[13:7]); a_s = int'(d[22:16]); a_d = int'(d[29:23]);
        if (a_m == 0 || a_m > 64) return 1;
        if (a_v > 64) return 2;
        if (a_s >= 64 || a_d >= 64) return 4;
        m_mvl = a_m; m_vl = (a_v > a_m) ? a_m : a_v; m_sub = int'(d[15:14]) + 1;
        m_src = a_s; m_dst = a_d;
      end
      default: ;
    endcase
    return 0;
  endfunction

  task automatic step(input bit we, input int sel, input logic [31:0] d,
                      input bit sv, input bit rs, input bit sw, input int lvl);
    logic [31:0] old_live, old_save;
    int cause;
    string tag;
    @(negedge clk);
    wr_en = we; wr_sel = 3'(sel); wr_data = d; t_save = sv; t_rest = rs;
    p_swap = sw; p_lvl = 2'(lvl);
    @(posedge clk); #1;
    old_live = live_word(); old_save = m_save; cause = 0;
    if (sv) m_save = old_live;
    if (rs) begin tag = "R10"; load_word(old_save); end
    else if (sw) begin
      tag = (lvl < 3) ? "R11" : "R12";
      if (lvl < 3) begin load_word(m_sh[lvl]); m_sh[lvl] = old_live; end
    end else if (we) begin
      cause = ref_write(sel, d);
      case (sel) 0: tag = "R3"; 1: tag = "R4"; 2: tag = "R5";
        3, 4: tag = "R6"; default: tag = "R7"; endcase
    end else tag = "R9";
    if (we && (rs || sw)) tag = "R12";
    chk(tag, state, live_word());
    chk("R9", save, m_save);
    chk("R8", {31'd0, ill}, {31'd0, cause != 0});
    chk("R8", {29'd0, ill_cause}, 32'(cause));
  endtask

  function automatic logic [31:0] rnd_val();
    int r = $urandom_range(0, 9);
    if (r == 0) return $urandom();
    if (r < 3) return 32'($urandom_range(0, 5));
    return 32'($urandom_range(0, 70));
  endfunction

  function automatic logic [31:0] rnd_pack();
    return {$urandom_range(0, 3) == 0 ? 2'b11 : 2'b00,
            7'($urandom_range(0, 70)), 7'($urandom_range(0, 70)),
            2'($urandom_range(0, 3)), 7'($urandom_range(0, 70)),
            7'($urandom_range(0, 70))};
  endfunction

  initial begin
    process::self().srandom(32'd1234);
    m_mvl = 1; m_vl = 0; m_sub = 1; m_src = 0; m_dst = 0;
    m_save = pack(1, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) m_sh[i] = pack(1, 0, 1, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", state, 32'h0000_0001);
    chk("R1", save, 32'h0000_0001);
    chk("R1", {29'd0, ill_cause, ill}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R3 boundaries
    step(1, 0, 0,  0, 0, 0, 0);
    step(1, 0, 65, 0, 0, 0, 0);
    step(1, 0, 64, 0, 0, 0, 0);
    // R4 clamp and bound
    step(1, 1, 64, 0, 0, 0, 0);
    step(1, 1, 65, 0, 0, 0, 0);
    step(1, 0, 10, 0, 0, 0, 0);
    step(1, 1, 30, 0, 0, 0, 0);
    // R5
    step(1, 2, 0, 0, 0, 0, 0);
    step(1, 2, 5, 0, 0, 0, 0);
    step(1, 2, 4, 0, 0, 0, 0);
    // R6
    step(1, 3, 63, 0, 0, 0, 0);
    step(1, 4, 64, 0, 0, 0, 0);
    step(1, 4, 9, 0, 0, 0, 0);
    // R2 explicit layout: max 10, len 10, group 4, src 63, dst 9
    chk("R2", state, 32'h04BF_C50A);
    // R7 ordering and ignored pad bits
    step(1, 5, {2'b11, 7'd70, 7'd70, 2'd0, 7'd70, 7'd0}, 0, 0, 0, 0);
    step(1, 5, {2'b00, 7'd70, 7'd70, 2'd0, 7'd70, 7'd5}, 0, 0, 0, 0);
    step(1, 5, {2'b00, 7'd3, 7'd64, 2'd1, 7'd2, 7'd5}, 0, 0, 0, 0);
    step(1, 5, {2'b11, 7'd3, 7'd4, 2'd1, 7'd40, 7'd20}, 0, 0, 0, 0);
    step(1, 6, 32'h5, 0, 0, 0, 0);
    // R9 save with write, R10 restore, R11 swaps, R12 blocked writes
    step(1, 1, 3, 1, 0, 0, 0);
    step(1, 0, 64, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2);
    step(1, 0, 0, 0, 0, 1, 3);
    step(0, 0, 0, 1, 1, 0, 0);
    step(0, 0, 0, 0, 1, 1, 1);
    step(0, 0, 0, 0, 0, 1, 2);

    for (int n = 0; n < N_RAND; n++) begin
      int sel = $urandom_range(0, 7);
      step($urandom_range(0, 9) < 6, sel, sel == 5 ? rnd_pack() : rnd_val(),
           $urandom_range(0, 9) == 0, $urandom_range(0, 11) == 0,
           $urandom_range(0, 11) == 0, $urandom_range(0, 3));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule